// File: doc/BRIEF.md
# Sequence-Gated Block Write Protection Controller

This block sits in front of a byte-wide nonvolatile array and decides, write by write, whether a byte is stored. Every write strobe it sees carries an address and a data byte. The block looks for two fixed command sequences in that stream. A three-byte sequence turns protection on for one block, and it also opens the way for one protected write burst. A six-byte sequence turns protection off for one block. The upper address bits pick the block, and each block keeps its own protection flag.

Writes are grouped into a page window. Each write restarts a countdown. When a write arrives in a protected block with no unlock sequence before it, the block raises no commit for it, but the window still closes normally and still signals the start of the program timer. Protection changes take hold only when the window closes. The flags are cleared only by a dedicated factory-clear input. A warm reset does not touch them.

Top module: `wgate_ctrl`

## Requirements
- R1: While `factory_clr_ni` is low, every protection flag reads 0. A warm reset (`rst_ni` low) leaves the flags unchanged, returns the detector to idle and drives both pulse outputs to 0.
- R2: When the detector is idle, an ordinary write commits exactly when the flag of its block is clear. The block is the top BLK_W address bits, and block n maps to `prot_o[n]`.
- R3: The arm sequence is three writes: data AAh at low address 5555h, then 55h at 2AAAh, then A0h at 5555h. Only address bits [14:0] are compared. These command bytes are never committed, and every data load that follows them in the same window is committed, including loads to protected blocks.
- R4: When a window that contains an arm sequence closes, exactly one flag is set. It is the flag of the block of the first data load after the sequence. If no data load followed, it is the flag of the block of the final command byte. No other flag changes.
- R5: The disarm sequence is six writes: AAh at 5555h, 55h at 2AAAh, 80h at 5555h, AAh at 5555h, 55h at 2AAAh, then 20h at 5555h. Its command bytes are not committed, the data loads after it are committed, and the flag it selects (chosen by the rule in R4) is cleared when the window closes.
- R6: A write that breaks the expected byte or address order sends the detector back to idle. That write is then handled as an ordinary write under R2.
- R7: A window closes WIN_CYC cycles after its last write, provided no further write arrives. At that edge `timer_start_o` pulses for one cycle and the detector returns to idle. This happens even when every write in the window was blocked.
- R8: `commit_o` is a one-cycle pulse that appears in the cycle after the write strobe that earned it. It is never high otherwise.
- R9: Protection flags change only at a window close or under factory clear. They never change while a window is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous warm reset (detector, timer, pulses) |
| factory_clr_ni | input | 1 | Active-low asynchronous clear of all protection flags |
| wr_valid_i | input | 1 | One-cycle write strobe |
| wr_addr_i | input | ADDR_W | Write address; top BLK_W bits select the block |
| wr_data_i | input | 8 | Write data byte |
| commit_o | output | 1 | Store the byte of the previous cycle's write |
| timer_start_o | output | 1 | Window closed; program timer starts |
| prot_o | output | 2**BLK_W | Protection flag per block |

## Verification
The bench builds the block with BLK_W=3, ADDR_W=18 and WIN_CYC=8. The three block bits give eight independent flags, so the tests can protect non-adjacent blocks, use the highest block, and give the command bytes a different block field from the data load. The short eight-cycle window lets many windows open and close in one run. That makes it practical to check flags while a window is still open, to let a half-entered sequence expire before its last byte, and to count program-timer pulses after blocked writes.

// File: rtl/wgate_pkg.sv
package wgate_pkg;
  localparam int CMD_W = 15;
  localparam logic [CMD_W-1:0] ADR_A = 15'h5555;
  localparam logic [CMD_W-1:0] ADR_B = 15'h2AAA;
  localparam logic [7:0] KEY_1    = 8'hAA;
  localparam logic [7:0] KEY_2    = 8'h55;
  localparam logic [7:0] CODE_ARM = 8'hA0;
  localparam logic [7:0] CODE_PFX = 8'h80;
  localparam logic [7:0] CODE_DIS = 8'h20;

  typedef enum logic [2:0] {
    ST_IDLE, ST_K1, ST_K2, ST_P3, ST_P4, ST_P5, ST_OPEN
  } seq_st_e;

  typedef enum logic [1:0] {OP_NONE, OP_SET, OP_CLR} prot_op_e;
endpackage

// File: rtl/wgate_win_timer.sv
module wgate_win_timer #(
  parameter int WIN_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kick_i,
  output logic expire_o
);
  localparam int CNT_W = $clog2(WIN_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WIN_CYC);

  logic [CNT_W-1:0] cnt_q;

  assign expire_o = (cnt_q == CNT_W'(1)) && !kick_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (kick_i)         cnt_q <= CNT_LOAD;
    else if (cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
  end
endmodule

// File: rtl/wgate_seq_fsm.sv
module wgate_seq_fsm
  import wgate_pkg::*;
#(
  parameter int BLK_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_valid_i,
  input  logic [CMD_W-1:0] addr_lo_i,
  input  logic [7:0]       data_i,
  input  logic [BLK_W-1:0] blk_i,
  input  logic             blk_prot_i,
  input  logic             expire_i,
  output logic             commit_o,
  output prot_op_e         apply_op_o,
  output logic [BLK_W-1:0] apply_blk_o
);
  seq_st_e          st_q, st_d;
  prot_op_e         op_q, op_d;
  logic [BLK_W-1:0] pblk_q, pblk_d;
  logic             first_q, first_d;
  logic             hit_a, hit_b, plain_wr;

  assign hit_a = (addr_lo_i == ADR_A);
  assign hit_b = (addr_lo_i == ADR_B);

  always_comb begin
    st_d     = st_q;
    op_d     = op_q;
    pblk_d   = pblk_q;
    first_d  = first_q;
    commit_o = 1'b0;
    plain_wr = 1'b0;
    if (expire_i) begin
      st_d = ST_IDLE;
      op_d = OP_NONE;
    end else if (wr_valid_i) begin
      case (st_q)
        ST_IDLE: if (data_i == KEY_1 && hit_a) st_d = ST_K1; else plain_wr = 1'b1;
        ST_K1:   if (data_i == KEY_2 && hit_b) st_d = ST_K2; else plain_wr = 1'b1;
        ST_K2: begin
          if (data_i == CODE_ARM && hit_a) begin
            st_d = ST_OPEN; op_d = OP_SET; pblk_d = blk_i; first_d = 1'b1;
          end else if (data_i == CODE_PFX && hit_a) begin
            st_d = ST_P3;
          end else plain_wr = 1'b1;
        end
        ST_P3:   if (data_i == KEY_1 && hit_a) st_d = ST_P4; else plain_wr = 1'b1;
        ST_P4:   if (data_i == KEY_2 && hit_b) st_d = ST_P5; else plain_wr = 1'b1;
        ST_P5: begin
          if (data_i == CODE_DIS && hit_a) begin
            st_d = ST_OPEN; op_d = OP_CLR; pblk_d = blk_i; first_d = 1'b1;
          end else plain_wr = 1'b1;
        end
        ST_OPEN: begin
          commit_o = 1'b1;
          if (first_q) begin
            pblk_d  = blk_i;
            first_d = 1'b0;
          end
        end
        default: plain_wr = 1'b1;
      endcase
      if (plain_wr) begin
        st_d     = ST_IDLE;
        commit_o = !blk_prot_i;
      end
    end
  end

  assign apply_op_o  = expire_i ? op_q : OP_NONE;
  assign apply_blk_o = pblk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      op_q    <= OP_NONE;
      pblk_q  <= '0;
      first_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      op_q    <= op_d;
      pblk_q  <= pblk_d;
      first_q <= first_d;
    end
  end
endmodule

// File: rtl/wgate_prot_flags.sv
module wgate_prot_flags
  import wgate_pkg::*;
#(
  parameter int BLK_W = 2,
  localparam int NBLK = 1 << BLK_W
) (
  input  logic             clk_i,
  input  logic             factory_clr_ni,
  input  prot_op_e         op_i,
  input  logic [BLK_W-1:0] blk_i,
  output logic [NBLK-1:0]  prot_o
);
  for (genvar g = 0; g < NBLK; g++) begin : g_blk
    logic flag_q;
    logic sel;
    assign sel = (blk_i == BLK_W'(g));
    always_ff @(posedge clk_i or negedge factory_clr_ni) begin
      if (!factory_clr_ni)                flag_q <= 1'b0;
      else if (sel && op_i == OP_SET)     flag_q <= 1'b1;
      else if (sel && op_i == OP_CLR)     flag_q <= 1'b0;
    end
    assign prot_o[g] = flag_q;
  end
endmodule

// File: rtl/wgate_ctrl.sv
module wgate_ctrl
  import wgate_pkg::*;
#(
  parameter int ADDR_W  = 17,
  parameter int BLK_W   = 2,
  parameter int WIN_CYC = 16,
  localparam int NBLK   = 1 << BLK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              factory_clr_ni,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  output logic              commit_o,
  output logic              timer_start_o,
  output logic [NBLK-1:0]   prot_o
);
  logic [BLK_W-1:0] blk;
  logic             expire, commit_d;
  prot_op_e         apply_op;
  logic [BLK_W-1:0] apply_blk;

  assign blk = wr_addr_i[ADDR_W-1 -: BLK_W];

  wgate_win_timer #(.WIN_CYC(WIN_CYC)) i_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .kick_i   (wr_valid_i),
    .expire_o (expire)
  );

  wgate_seq_fsm #(.BLK_W(BLK_W)) i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_valid_i  (wr_valid_i),
    .addr_lo_i   (wr_addr_i[CMD_W-1:0]),
    .data_i      (wr_data_i),
    .blk_i       (blk),
    .blk_prot_i  (prot_o[blk]),
    .expire_i    (expire),
    .commit_o    (commit_d),
    .apply_op_o  (apply_op),
    .apply_blk_o (apply_blk)
  );

  wgate_prot_flags #(.BLK_W(BLK_W)) i_flags (
    .clk_i          (clk_i),
    .factory_clr_ni (factory_clr_ni),
    .op_i           (apply_op),
    .blk_i          (apply_blk),
    .prot_o         (prot_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      commit_o      <= 1'b0;
      timer_start_o <= 1'b0;
    end else begin
      commit_o      <= commit_d;
      timer_start_o <= expire;
    end
  end
endmodule

// File: rtl/wgate_ctrl_chk.sv
module wgate_ctrl_chk #(
  parameter int NBLK = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            factory_clr_ni,
  input logic            wr_valid_i,
  input logic            commit_o,
  input logic            timer_start_o,
  input logic [NBLK-1:0] prot_o
);
  // R8
  commit_after_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> $past(wr_valid_i));

  // R7
  close_needs_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timer_start_o |-> !$past(wr_valid_i));

  // R9
  flags_hold_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !factory_clr_ni)
    !timer_start_o |-> $stable(prot_o));

  // R4
  one_flag_per_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !factory_clr_ni)
    timer_start_o |-> $countones(prot_o ^ $past(prot_o)) <= 1);

  // R1
  factory_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !factory_clr_ni |-> prot_o == '0);

  // R8
  commit_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> !commit_o || $past(wr_valid_i));
endmodule

bind wgate_ctrl wgate_ctrl_chk #(.NBLK(NBLK)) i_wgate_ctrl_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .factory_clr_ni (factory_clr_ni),
  .wr_valid_i     (wr_valid_i),
  .commit_o       (commit_o),
  .timer_start_o  (timer_start_o),
  .prot_o         (prot_o)
);

// File: tb/test_wgate_ctrl.sv
module test_wgate_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 18;
  localparam int BLK_W  = 3;
  localparam int WIN    = 8;
  localparam int NBLK   = 1 << BLK_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              fclr_n = 1'b0;
  logic              wr_v = 1'b0;
  logic [ADDR_W-1:0] wr_a = '0;
  logic [7:0]        wr_d = '0;
  logic              commit;
  logic              tstart;
  logic [NBLK-1:0]   prot;

  int n_chk = 0;
  int n_fail = 0;
  int tcount = 0;
  bit    exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  wgate_ctrl #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .WIN_CYC(WIN)) i_wgate_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .factory_clr_ni(fclr_n),
    .wr_valid_i(wr_v), .wr_addr_i(wr_a), .wr_data_i(wr_d),
    .commit_o(commit), .timer_start_o(tstart), .prot_o(prot)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // driver: one write, expected commit pushed to scoreboard
  task automatic wr(logic [BLK_W-1:0] b, logic [14:0] lo, logic [7:0] d, bit exp, string req);
    @(negedge clk);
    wr_v = 1'b1;
    wr_a = {b, lo};
    wr_d = d;
    exp_q.push_back(exp);
    tag_q.push_back(req);
    @(negedge clk);
    wr_v = 1'b0;
  endtask

  task automatic arm(logic [BLK_W-1:0] b, string req);
    wr(b, 15'h5555, 8'hAA, 1'b0, req);
    wr(b, 15'h2AAA, 8'h55, 1'b0, req);
    wr(b, 15'h5555, 8'hA0, 1'b0, req);
  endtask

  task automatic disarm(logic [BLK_W-1:0] b, string req);
    wr(b, 15'h5555, 8'hAA, 1'b0, req);
    wr(b, 15'h2AAA, 8'h55, 1'b0, req);
    wr(b, 15'h5555, 8'h80, 1'b0, req);
    wr(b, 15'h5555, 8'hAA, 1'b0, req);
    wr(b, 15'h2AAA, 8'h55, 1'b0, req);
    wr(b, 15'h5555, 8'h20, 1'b0, req);
  endtask

  task automatic close_win();
    repeat (WIN + 2) @(negedge clk);
  endtask

  // monitor: compares commit_o one cycle after each strobe, counts window closes
  always @(posedge clk) begin : mon
    logic had;
    bit e;
    string t;
    had = wr_v;
    #(CLK_PERIOD/4);
    if (tstart) tcount++;
    if (had) begin
      if (exp_q.size() == 0) check("R8 queue", 1, 0);
      else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, int'(commit), int'(e));
      end
    end else if (rst_n && commit) begin
      check("R8 stray commit", 1, 0);
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    int t0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 flags", int'(prot), 0);
    check("R1 commit", int'(commit), 0);
    check("R1 tstart", int'(tstart), 0);
    rst_n = 1'b1;
    fclr_n = 1'b1;

    // R2 plain write, R7 window close pulse
    t0 = tcount;
    wr(3'd0, 15'h0123, 8'h3C, 1'b1, "R2 plain unprotected");
    close_win();
    check("R7 one close pulse", tcount - t0, 1);

    // R3 arm with data to blk2 then blk6; R4 first load picks block; R9 no change while open
    arm(3'd0, "R3 cmd byte");
    wr(3'd2, 15'h0010, 8'h11, 1'b1, "R3 load after arm");
    wr(3'd6, 15'h0011, 8'h22, 1'b1, "R3 second load");
    check("R9 open window", int'(prot), 0);
    close_win();
    check("R4 first load block", int'(prot), 8'h04);

    // R2 blocked write still closes a window (R7); independent blocks
    t0 = tcount;
    wr(3'd2, 15'h0040, 8'h99, 1'b0, "R2 protected dropped");
    close_win();
    check("R7 blocked write timer", tcount - t0, 1);
    wr(3'd1, 15'h0040, 8'h99, 1'b1, "R2 other block open");
    close_win();

    // R3 protected write with unlock
    arm(3'd2, "R3 cmd byte");
    wr(3'd2, 15'h0041, 8'h5A, 1'b1, "R3 unlocked protected load");
    close_win();
    check("R4 rearm same block", int'(prot), 8'h04);

    // R4 arm with no data: block of final command byte
    arm(3'd5, "R3 cmd byte");
    close_win();
    check("R4 no-data arm", int'(prot), 8'h24);

    // R6 broken sequences
    wr(3'd0, 15'h5555, 8'hAA, 1'b0, "R6 cmd start");
    wr(3'd3, 15'h1234, 8'h55, 1'b1, "R6 wrong addr as data");
    wr(3'd0, 15'h5555, 8'hA0, 1'b1, "R6 idle A0 as data");
    wr(3'd0, 15'h5555, 8'hAA, 1'b0, "R6 cmd start");
    wr(3'd2, 15'h2AAA, 8'h77, 1'b0, "R6 wrong data to protected");
    close_win();
    check("R6 no flag change", int'(prot), 8'h24);

    // R5 disarm without data
    disarm(3'd5, "R5 cmd byte");
    check("R9 disarm open", int'(prot), 8'h24);
    close_win();
    check("R5 no-data disarm", int'(prot), 8'h04);

    // R5 disarm with data to blk2
    disarm(3'd0, "R5 cmd byte");
    wr(3'd2, 15'h0050, 8'h01, 1'b1, "R5 load after disarm");
    wr(3'd6, 15'h0051, 8'h02, 1'b1, "R5 second load");
    close_win();
    check("R5 disarm first load", int'(prot), 0);

    // R7 window expiry returns detector to idle mid-sequence
    wr(3'd0, 15'h5555, 8'hAA, 1'b0, "R7 cmd");
    wr(3'd0, 15'h2AAA, 8'h55, 1'b0, "R7 cmd");
    close_win();
    wr(3'd0, 15'h5555, 8'hA0, 1'b1, "R7 late A0 is data");
    close_win();
    check("R7 no arm after expiry", int'(prot), 0);

    // R1 warm reset keeps flags, factory clear drops them
    arm(3'd7, "R3 cmd byte");
    close_win();
    check("R4 top block", int'(prot), 8'h80);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 warm reset outputs", int'({commit, tstart}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 warm reset keeps flags", int'(prot), 8'h80);
    fclr_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 factory clear", int'(prot), 0);
    fclr_n = 1'b1;
    @(negedge clk);
    wr(3'd7, 15'h0001, 8'hEE, 1'b1, "R2 after factory clear");
    close_win();
    check("R8 scoreboard drained", exp_q.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule